// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Capture Controller

This block receives message-signalled interrupts on behalf of a host processor. An upstream bridge turns each inbound interrupt message into a 32-bit write on the vector window. Every vector owns one word in that window, and the data written is the vector's own index. The block keeps one pending flag per vector. It drives a single level interrupt to the host for as long as any enabled flag is pending.

The host uses a second slave port to program an enable mask, read the pending status and read or clear a small error register. It services the interrupt by reading status until the value is zero. Each pending vector is acknowledged by reading that vector's own word in the vector window. Both ports share one register-bus form: a valid with a tied-high ready, a write strobe, and read data that returns exactly one cycle after the request is accepted. The number of vectors is the parameter `NUM_VEC`, at most 32.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the pending flags, the enable mask and the error register are all zero and `irq_o` is low.
- R2: The control port decodes `cs_addr[3:2]`: 0 selects status (offset 0x0), 1 selects error (0x4), 2 selects mask (0x8), and 3 reads zero. Read data and `cs_rvalid` appear in the cycle after the read is accepted. Both ready outputs are always high.
- R3: Vector n owns byte offset 4*n of the vector window. A write to that offset with data equal to n, while mask bit n is set, makes vector n pending from the next cycle. The status register shows vector n at bit n.
- R4: A write to a vector whose mask bit is clear leaves no pending state. Clearing a mask bit discards that vector's pending flag, so writing 0 to the mask disables and discards every vector.
- R5: A read of vector n's word returns zero data with `vw_rvalid` one cycle later. The same read clears vector n's pending flag at the clock edge one cycle after the read is accepted.
- R6: If a read clear and a new valid write reach the same vector at the same clock edge, the vector stays pending.
- R7: `irq_o` is high exactly while at least one pending flag is set.
- R8: A vector-window write to a slot at or above `NUM_VEC` sets error bit 0. A write to an in-range slot whose data differs from the slot index sets error bit 1. Neither kind of write sets a pending flag.
- R9: Writing a one to an error bit clears that bit. If a new error for the same bit arrives at the same clock edge, the bit stays set.
- R10: Mask bits at and above `NUM_VEC` cannot be set and read as zero.
- R11: Reading status does not clear it. A vector that arrives while others are being serviced appears in the next status read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vw_valid | input | 1 | Vector window request valid |
| vw_ready | output | 1 | Vector window ready, always high |
| vw_write | input | 1 | Vector window request is a write |
| vw_addr | input | 7 | Vector window byte address |
| vw_wdata | input | 32 | Vector window write data (message data) |
| vw_rvalid | output | 1 | Vector window read data valid |
| vw_rdata | output | 32 | Vector window read data, always zero |
| cs_valid | input | 1 | Control port request valid |
| cs_ready | output | 1 | Control port ready, always high |
| cs_write | input | 1 | Control port request is a write |
| cs_addr | input | 4 | Control port byte address |
| cs_wdata | input | 32 | Control port write data |
| cs_rvalid | output | 1 | Control port read data valid |
| cs_rdata | output | 32 | Control port read data |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
Several properties are checked on every cycle. A well-formed enabled write sets its flag. A mismatched write leaves its flag clear. An out-of-range write raises error bit 0. No flag is ever pending without its mask bit. The interrupt agrees with the masked pending set. Control reads return on time. The bench scenarios are needed for behaviour that spans several transactions across both ports: the one-cycle delay of the read clear and its collision with a new write, arrivals during a status-polling loop, discarding on mask clear, error write-one-to-clear with a simultaneous new error, and the masking of upper mask bits for a reduced vector count.

// File: rtl/msi_cap_pkg.sv
// Shared constants and types for the vector capture controller.
package msi_cap_pkg;
    localparam int MAX_VEC = 32;
    localparam int DATA_W  = 32;
    localparam int CSR_AW  = 4;
    localparam int SLOT_W  = $clog2(MAX_VEC);
    localparam int VW_AW   = SLOT_W + 2;

    // Error register bit positions.
    localparam int ERR_RANGE = 0;
    localparam int ERR_DATA  = 1;
    localparam int ERR_W     = 2;

    // Control register select, taken from cs_addr[3:2].
    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ERROR  = 2'd1,
        SEL_MASK   = 2'd2,
        SEL_RSVD   = 2'd3
    } csr_sel_e;
endpackage

// File: rtl/msi_vec_port.sv
// Vector window decoder.
// Turns writes into per-vector set strobes and error strobes, and turns
// reads into per-vector clear strobes one cycle later.
// Assumes word-aligned accesses; the low two address bits are ignored.
module msi_vec_port
    import msi_cap_pkg::*;
#(
    parameter int NUM_VEC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid,
    input  logic               write,
    input  logic [VW_AW-1:0]   addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic               ready,
    output logic               rvalid,
    output logic [DATA_W-1:0]  rdata,
    output logic [NUM_VEC-1:0] set_vec,
    output logic [NUM_VEC-1:0] clr_vec,
    output logic [ERR_W-1:0]   err_set
);
    logic [SLOT_W-1:0] slot;
    logic              in_range;
    logic              data_ok;
    logic              wr_acc;
    logic              rd_acc;
    logic              rd_q;
    logic [SLOT_W-1:0] rd_slot_q;
    logic              unused_addr;

    assign ready       = 1'b1;
    assign slot        = addr[VW_AW-1:2];
    assign unused_addr = ^addr[1:0];
    assign in_range    = 32'(slot) < 32'(NUM_VEC);
    assign data_ok     = wdata == 32'(slot);
    assign wr_acc      = valid && write;
    assign rd_acc      = valid && !write;

    // Error strobes: a range fault takes precedence over a data fault.
    assign err_set[ERR_RANGE] = wr_acc && !in_range;
    assign err_set[ERR_DATA]  = wr_acc && in_range && !data_ok;

    // Register accepted reads; the clear and the read data come out one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q      <= 1'b0;
            rd_slot_q <= '0;
        end else begin
            rd_q      <= rd_acc;
            rd_slot_q <= slot;
        end
    end

    assign rvalid = rd_q;
    assign rdata  = '0;

    // One set and one clear decoder per vector.
    for (genvar i = 0; i < NUM_VEC; i++) begin : g_dec
        localparam logic [SLOT_W-1:0] IDX = SLOT_W'(i);
        assign set_vec[i] = wr_acc && data_ok && (slot == IDX);
        assign clr_vec[i] = rd_q && (rd_slot_q == IDX);
    end
endmodule

// File: rtl/msi_csr_port.sv
// Control/status port.
// Holds the enable mask and the error register, and returns read data one
// cycle after a read is accepted. Assumes word-aligned accesses.
module msi_csr_port
    import msi_cap_pkg::*;
#(
    parameter int NUM_VEC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid,
    input  logic               write,
    input  logic [CSR_AW-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic               ready,
    output logic               rvalid,
    output logic [DATA_W-1:0]  rdata,
    input  logic [ERR_W-1:0]   err_set,
    input  logic [NUM_VEC-1:0] pend,
    output logic [NUM_VEC-1:0] mask_q,
    output logic [NUM_VEC-1:0] mask_d,
    output logic [ERR_W-1:0]   err_q
);
    csr_sel_e          sel;
    logic              wr_acc;
    logic              rd_acc;
    logic [ERR_W-1:0]  err_clr;
    logic [DATA_W-1:0] rd_mux;
    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;
    logic              unused_bits;

    assign ready       = 1'b1;
    assign sel         = csr_sel_e'(addr[3:2]);
    assign unused_bits = ^{addr[1:0], wdata};
    assign wr_acc      = valid && write;
    assign rd_acc      = valid && !write;

    // Next mask value; the pending array needs it in the same cycle.
    always_comb begin
        mask_d = mask_q;
        if (wr_acc && sel == SEL_MASK) mask_d = wdata[NUM_VEC-1:0];
    end

    // Write-one-to-clear request for the error register.
    always_comb begin
        err_clr = '0;
        if (wr_acc && sel == SEL_ERROR) err_clr = wdata[ERR_W-1:0];
    end

    // Mask and error state; a new error beats a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            err_q  <= '0;
        end else begin
            mask_q <= mask_d;
            err_q  <= (err_q & ~err_clr) | err_set;
        end
    end

    // Read multiplexer over the current register values.
    always_comb begin
        unique case (sel)
            SEL_STATUS: rd_mux = 32'(pend);
            SEL_ERROR:  rd_mux = 32'(err_q);
            SEL_MASK:   rd_mux = 32'(mask_q);
            default:    rd_mux = '0;
        endcase
    end

    // Read return stage, fixed one-cycle latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= rd_acc;
            rdata_q  <= rd_acc ? rd_mux : '0;
        end
    end

    assign rvalid = rvalid_q;
    assign rdata  = rdata_q;
endmodule

// File: rtl/msi_pend_array.sv
// Pending flag array.
// Holds one flag per vector. A disabled vector is held clear; for an
// enabled vector, a set beats a clear. Uses the next mask value so that a
// flag never outlives its enable.
module msi_pend_array #(
    parameter int NUM_VEC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] set_vec,
    input  logic [NUM_VEC-1:0] clr_vec,
    input  logic [NUM_VEC-1:0] mask_d,
    output logic [NUM_VEC-1:0] pend,
    output logic               irq
);
    for (genvar i = 0; i < NUM_VEC; i++) begin : g_flag
        // Per-vector flag update with mask > set > clear priority.
        always_ff @(posedge clk) begin
            if (!rst_n)            pend[i] <= 1'b0;
            else if (!mask_d[i])   pend[i] <= 1'b0;
            else if (set_vec[i])   pend[i] <= 1'b1;
            else if (clr_vec[i])   pend[i] <= 1'b0;
        end
    end

    assign irq = |pend;
endmodule

// File: rtl/msi_capture_ctrl.sv
// Vector capture controller top.
// Joins the vector window decoder, the control port and the pending array.
// Assumes at most one request per port per cycle, and NUM_VEC between 1 and 32.
module msi_capture_ctrl
    import msi_cap_pkg::*;
#(
    parameter int NUM_VEC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vw_valid,
    output logic              vw_ready,
    input  logic              vw_write,
    input  logic [VW_AW-1:0]  vw_addr,
    input  logic [DATA_W-1:0] vw_wdata,
    output logic              vw_rvalid,
    output logic [DATA_W-1:0] vw_rdata,
    input  logic              cs_valid,
    output logic              cs_ready,
    input  logic              cs_write,
    input  logic [CSR_AW-1:0] cs_addr,
    input  logic [DATA_W-1:0] cs_wdata,
    output logic              cs_rvalid,
    output logic [DATA_W-1:0] cs_rdata,
    output logic              irq_o
);
    logic [NUM_VEC-1:0] set_vec;
    logic [NUM_VEC-1:0] clr_vec;
    logic [ERR_W-1:0]   err_set;
    logic [NUM_VEC-1:0] pend_q;
    logic [NUM_VEC-1:0] mask_q;
    logic [NUM_VEC-1:0] mask_d;
    logic [ERR_W-1:0]   err_q;

    msi_vec_port #(.NUM_VEC(NUM_VEC)) u_vec (
        .clk(clk), .rst_n(rst_n),
        .valid(vw_valid), .write(vw_write), .addr(vw_addr), .wdata(vw_wdata),
        .ready(vw_ready), .rvalid(vw_rvalid), .rdata(vw_rdata),
        .set_vec(set_vec), .clr_vec(clr_vec), .err_set(err_set)
    );

    msi_csr_port #(.NUM_VEC(NUM_VEC)) u_csr (
        .clk(clk), .rst_n(rst_n),
        .valid(cs_valid), .write(cs_write), .addr(cs_addr), .wdata(cs_wdata),
        .ready(cs_ready), .rvalid(cs_rvalid), .rdata(cs_rdata),
        .err_set(err_set), .pend(pend_q),
        .mask_q(mask_q), .mask_d(mask_d), .err_q(err_q)
    );

    msi_pend_array #(.NUM_VEC(NUM_VEC)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .set_vec(set_vec), .clr_vec(clr_vec), .mask_d(mask_d),
        .pend(pend_q), .irq(irq_o)
    );
endmodule

// File: rtl/msi_capture_ctrl_chk.sv
// Property checker for the vector capture controller, bound to the top.
// Observes the ports and the pending, mask and error state.
module msi_capture_ctrl_chk
    import msi_cap_pkg::*;
#(
    parameter int NUM_VEC = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               vw_valid,
    input logic               vw_write,
    input logic [VW_AW-1:0]   vw_addr,
    input logic [DATA_W-1:0]  vw_wdata,
    input logic               cs_valid,
    input logic               cs_write,
    input logic               cs_rvalid,
    input logic               irq,
    input logic [NUM_VEC-1:0] pend,
    input logic [NUM_VEC-1:0] mask,
    input logic [ERR_W-1:0]   err
);
    logic [SLOT_W-1:0] slot;
    logic [31:0]       p32;
    logic [31:0]       m32;
    logic              in_rng;
    logic              good_wr;
    logic              bad_data_wr;

    assign slot        = vw_addr[VW_AW-1:2];
    assign p32         = 32'(pend);
    assign m32         = 32'(mask);
    assign in_rng      = 32'(slot) < 32'(NUM_VEC);
    assign good_wr     = vw_valid && vw_write && in_rng && (vw_wdata == 32'(slot))
                         && m32[slot] && !(cs_valid && cs_write);
    assign bad_data_wr = vw_valid && vw_write && in_rng && (vw_wdata != 32'(slot))
                         && !p32[slot];

    AST_RESET_CLEAN: assert property (@(posedge clk) $rose(rst_n) |-> (p32 == 0 && m32 == 0 && err == 0)); // R1
    AST_CSR_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) cs_valid && !cs_write |=> cs_rvalid); // R2
    AST_VEC_SET: assert property (@(posedge clk) disable iff (!rst_n) good_wr |=> p32[$past(slot)]); // R3
    AST_PEND_WITHIN_MASK: assert property (@(posedge clk) disable iff (!rst_n) (p32 & ~m32) == 0); // R4
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (p32 & m32) != 0); // R7
    AST_IRQ_NO_SILENT: assert property (@(posedge clk) disable iff (!rst_n) !irq |-> p32 == 0); // R7
    AST_RANGE_ERR: assert property (@(posedge clk) disable iff (!rst_n) vw_valid && vw_write && !in_rng |=> err[ERR_RANGE]); // R8
    AST_BAD_DATA_NO_SET: assert property (@(posedge clk) disable iff (!rst_n) bad_data_wr |=> !p32[$past(slot)]); // R8
endmodule

bind msi_capture_ctrl msi_capture_ctrl_chk #(.NUM_VEC(NUM_VEC)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .vw_valid(vw_valid), .vw_write(vw_write), .vw_addr(vw_addr), .vw_wdata(vw_wdata),
    .cs_valid(cs_valid), .cs_write(cs_write), .cs_rvalid(cs_rvalid),
    .irq(irq_o), .pend(pend_q), .mask(mask_q), .err(err_q)
);

// File: tb/msi_capture_ctrl_tb.sv
`timescale 1ns/1ps
module msi_capture_ctrl_tb;
    localparam int NV = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vw_valid = 1'b0, vw_write = 1'b0;
    logic [6:0]  vw_addr = '0;
    logic [31:0] vw_wdata = '0;
    logic        vw_ready, vw_rvalid;
    logic [31:0] vw_rdata;
    logic        cs_valid = 1'b0, cs_write = 1'b0;
    logic [3:0]  cs_addr = '0;
    logic [31:0] cs_wdata = '0;
    logic        cs_ready, cs_rvalid;
    logic [31:0] cs_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    msi_capture_ctrl #(.NUM_VEC(NV)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .vw_valid(vw_valid), .vw_ready(vw_ready), .vw_write(vw_write),
        .vw_addr(vw_addr), .vw_wdata(vw_wdata), .vw_rvalid(vw_rvalid), .vw_rdata(vw_rdata),
        .cs_valid(cs_valid), .cs_ready(cs_ready), .cs_write(cs_write),
        .cs_addr(cs_addr), .cs_wdata(cs_wdata), .cs_rvalid(cs_rvalid), .cs_rdata(cs_rdata),
        .irq_o(irq_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver tasks: called at a negedge, return at the next negedge.
    task automatic cs_wr(logic [3:0] a, logic [31:0] d);
        cs_valid = 1'b1; cs_write = 1'b1; cs_addr = a; cs_wdata = d;
        @(negedge clk);
        cs_valid = 1'b0; cs_write = 1'b0;
    endtask

    task automatic cs_rd(logic [3:0] a, logic [31:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        cs_valid = 1'b1; cs_write = 1'b0; cs_addr = a;
        @(negedge clk);
        cs_valid = 1'b0;
    endtask

    task automatic vw_wr(int slot, logic [31:0] d);
        vw_valid = 1'b1; vw_write = 1'b1; vw_addr = 7'(slot * 4); vw_wdata = d;
        @(negedge clk);
        vw_valid = 1'b0; vw_write = 1'b0;
    endtask

    task automatic vw_rd(int slot);
        vw_valid = 1'b1; vw_write = 1'b0; vw_addr = 7'(slot * 4);
        @(negedge clk);
        vw_valid = 1'b0;
        check("R5 vector read rvalid", 32'(vw_rvalid), 32'd1);
        check("R5 vector read data", vw_rdata, 32'd0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: pops the expected value for each returned control read.
    always @(negedge clk) begin
        if (rst_n && cs_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected read return", 32'd1, 32'd0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, cs_rdata, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1 irq after reset", 32'(irq_o), 32'd0);
        check("R2 ready high", 32'({vw_ready, cs_ready}), 32'd3);
        cs_rd(4'h0, 32'h0, "R1 status after reset");
        cs_rd(4'h4, 32'h0, "R1 error after reset");
        cs_rd(4'h8, 32'h0, "R1 mask after reset");
        cs_rd(4'hC, 32'h0, "R2 reserved offset");
        // R4 write to a disabled vector is dropped
        vw_wr(3, 32'd3);
        check("R4 irq after masked write", 32'(irq_o), 32'd0);
        cs_wr(4'h8, 32'h8);
        cs_rd(4'h0, 32'h0, "R4 masked write left no pending");
        cs_wr(4'h8, 32'hFF);
        cs_rd(4'h8, 32'hFF, "R2 mask readback");
        // R3 vector set
        vw_wr(5, 32'd5);
        check("R7 irq with pending", 32'(irq_o), 32'd1);
        cs_rd(4'h0, 32'h20, "R3 vector 5 pending");
        vw_wr(2, 32'd2);
        cs_rd(4'h0, 32'h24, "R3 vectors 2 and 5 pending");
        // R5 clear by slot read
        vw_rd(5);
        idle(1);
        cs_rd(4'h0, 32'h04, "R5 vector 5 cleared");
        // R6 set beats a clear landing at the same edge
        vw_rd(2);
        vw_wr(2, 32'd2);
        idle(1);
        cs_rd(4'h0, 32'h04, "R6 set wins over clear");
        // R11 arrivals during service remain visible
        cs_rd(4'h0, 32'h04, "R11 status read does not clear");
        vw_wr(7, 32'd7);
        vw_rd(2);
        idle(1);
        cs_rd(4'h0, 32'h80, "R11 late arrival visible");
        vw_rd(7);
        idle(1);
        check("R7 irq low when drained", 32'(irq_o), 32'd0);
        cs_rd(4'h0, 32'h0, "R5 all drained");
        // R8 error detection
        vw_wr(24, 32'd24);
        cs_rd(4'h4, 32'h1, "R8 range error");
        vw_wr(6, 32'd9);
        cs_rd(4'h4, 32'h3, "R8 data error");
        cs_rd(4'h0, 32'h0, "R8 bad writes set no pending");
        // R9 write-one-to-clear
        cs_wr(4'h4, 32'h1);
        cs_rd(4'h4, 32'h2, "R9 clear bit 0");
        cs_wr(4'h4, 32'h2);
        cs_rd(4'h4, 32'h0, "R9 clear bit 1");
        // R9 new error beats a simultaneous clear
        cs_valid = 1'b1; cs_write = 1'b1; cs_addr = 4'h4; cs_wdata = 32'h1;
        vw_valid = 1'b1; vw_write = 1'b1; vw_addr = 7'(30 * 4); vw_wdata = 32'd30;
        @(negedge clk);
        cs_valid = 1'b0; cs_write = 1'b0; vw_valid = 1'b0; vw_write = 1'b0;
        cs_rd(4'h4, 32'h1, "R9 set wins over clear");
        cs_wr(4'h4, 32'h1);
        // R10 upper mask bits
        cs_wr(4'h8, 32'hFFFF_FFFF);
        cs_rd(4'h8, 32'h00FF_FFFF, "R10 upper mask bits read zero");
        vw_wr(23, 32'd23);
        cs_rd(4'h0, 32'h0080_0000, "R3 highest vector");
        vw_wr(0, 32'd0);
        cs_rd(4'h0, 32'h0080_0001, "R3 lowest vector");
        // R4 disable all
        cs_wr(4'h8, 32'h0);
        check("R4 irq after disable all", 32'(irq_o), 32'd0);
        cs_rd(4'h0, 32'h0, "R4 disable all clears status");
        cs_wr(4'h8, 32'hFFFF_FFFF);
        cs_rd(4'h0, 32'h0, "R4 pending discarded on disable");
        idle(2);
        check("R2 all reads returned", 32'(exp_q.size()), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule